// File: doc/BRIEF.md
# Parallel Slave Port Interface

This block gives an external master processor access to four byte-wide registers inside a microcontroller. The master uses an 8-bit parallel bus with an active-low chip select, active-low read and write strobes, and a single address-latch pin. The bus is split into separate input, output and output-enable signals. On the master side, reads return either the outgoing data byte or a status byte, and writes deposit either an incoming data byte or a command byte. The local CPU reaches the same registers through a simple strobe-based local port, and it can raise an active-high interrupt toward the master.

The block has two bus modes, chosen by a static mode input. In multiplexed mode, the address-latch pin samples bit 1 of the shared bus, and the sampled bit becomes the register select. In demultiplexed mode, the level of the address-latch pin is itself the register select, and the bus carries only data. All master pins are brought into the core clock through two flip-flops. Strobe edges are found in the core domain before any register changes.

Top module: `pslv_port`

## Requirements
- R1: After reset the bus is released (`bus_oe`=0, `bus_out`=0), `irq` is 0, `loc_din` and `loc_cmd` are 0, and the status byte reads 0x00.
- R2: While `cs_n` is high, read and write strobes have no effect: no register or flag changes and the bus is not driven.
- R3: `bus_oe` is 1 exactly while the synchronized `cs_n` and `rd_n` are both low. This is two clock edges after the pins settle. `bus_out` is 0 whenever `bus_oe` is 0.
- R4: A read with select 0 drives the data-out byte. A read with select 1 drives the status byte. Status bit 0 = data-in full, bit 1 = data-out full, bit 2 = interrupt, bits 7:3 = 0.
- R5: The rising edge of `wr_n` with chip select low captures `bus_in`. It goes into the data-in register for select 0 and into the command register for select 1. The captured byte shows on `loc_din` or `loc_cmd` three clock edges after the pin rises.
- R6: In multiplexed mode (`mux_mode`=1), the select is bus bit 1 sampled while the synchronized address-latch input is high. The select holds its value after that input falls, whatever the data phase carries on bit 1.
- R7: In demultiplexed mode (`mux_mode`=0), the select is the synchronized level of `ale`, and bus bit 1 plays no part in selection.
- R8: The data-in-full flag sets on a master write to data-in. It clears on a `loc_din_rd` pulse. If both happen in the same cycle, the set wins.
- R9: The data-out-full flag sets on `loc_dout_we`, which also loads the data-out byte. It clears at the end (rising `rd_n`) of a master read of data-out. If both happen in the same cycle, the set wins.
- R10: `irq` is active high. It sets on `loc_irq_set` and clears at the end of a master read of the status byte. If both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode | input | 1 | 1 = multiplexed address/data, 0 = demultiplexed; held stable while selected |
| cs_n | input | 1 | Master chip select, active low |
| ale | input | 1 | Address latch enable (multiplexed) or register select (demultiplexed) |
| rd_n | input | 1 | Master read strobe, active low |
| wr_n | input | 1 | Master write strobe, active low |
| bus_in | input | 8 | Bus value seen at the pins |
| bus_out | output | 8 | Byte driven toward the master |
| bus_oe | output | 1 | Bus driver enable |
| irq | output | 1 | Interrupt to the master, active high |
| loc_dout_we | input | 1 | Local write of the data-out byte |
| loc_dout_wdata | input | 8 | Local data-out byte |
| loc_din_rd | input | 1 | Local acknowledge of the data-in byte |
| loc_din | output | 8 | Data-in byte as seen by the local CPU |
| loc_cmd | output | 8 | Command byte as seen by the local CPU |
| loc_irq_set | input | 1 | Local request to raise `irq` |

## Verification
A wrong select latch or wrong synchronizer state shows at the ports within three edges of the next strobe. The symptoms are a byte landing in the wrong register on `loc_din`/`loc_cmd`, or the wrong byte driven while `bus_oe` is high. Flag errors surface on the next status read, and a stale interrupt flag shows on `irq` in the same cycle. The bench keeps a behavioural model of the pin delays and flags, and it compares every output on every clock. Because of this, a mistake is seen in the first cycle it becomes visible, and not only at the end of a transaction.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
  // Status byte bit positions (the master decodes these)
  localparam int unsigned ST_IBF = 0;
  localparam int unsigned ST_OBF = 1;
  localparam int unsigned ST_IRQ = 2;
  localparam int unsigned ST_FLAGS = 3;

  // Register select in force for the current cycle
  function automatic logic pick_sel(input logic mux, input logic latched, input logic ale_lvl);
    return mux ? latched : ale_lvl;
  endfunction

  // Flag update: clear request first, set request wins
  function automatic logic next_flag(input logic cur, input logic set_req, input logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST[i]}};
      else        st <= {st[0], din[i]};
    end
    assign dout[i] = st[1];
  end
endmodule

// File: rtl/pslv_edge.sv
module pslv_edge #(
  parameter int unsigned N = 2,
  parameter logic [N-1:0] RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/pslv_addr.sv
module pslv_addr import pslv_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic mux_mode,
  input  logic ale_s,
  input  logic addr_bit,
  output logic sel
);
  logic lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= 1'b0;
    else if (ale_s) lat_q <= addr_bit;
  end
  assign sel = pick_sel(mux_mode, lat_q, ale_s);
endmodule

// File: rtl/pslv_regs.sv
module pslv_regs import pslv_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_din_evt,
  input  logic          wr_cmd_evt,
  input  logic          rd_dout_evt,
  input  logic          rd_stat_evt,
  input  logic [DW-1:0] bus_in,
  input  logic          loc_dout_we,
  input  logic [DW-1:0] loc_dout_wdata,
  input  logic          loc_din_rd,
  input  logic          loc_irq_set,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] din,
  output logic [DW-1:0] cmd,
  output logic [DW-1:0] status,
  output logic          irq
);
  logic ibf, obf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      din  <= '0;
      cmd  <= '0;
      ibf  <= 1'b0;
      obf  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (wr_din_evt)  din  <= bus_in;
      if (wr_cmd_evt)  cmd  <= bus_in;
      if (loc_dout_we) dout <= loc_dout_wdata;
      ibf <= next_flag(ibf, wr_din_evt, loc_din_rd);
      obf <= next_flag(obf, loc_dout_we, rd_dout_evt);
      irq <= next_flag(irq, loc_irq_set, rd_stat_evt);
    end
  end

  always_comb begin
    status         = '0;
    status[ST_IBF] = ibf;
    status[ST_OBF] = obf;
    status[ST_IRQ] = irq;
  end
endmodule

// File: rtl/pslv_port.sv
module pslv_port import pslv_pkg::*; #(
  parameter int unsigned DW       = 8,
  parameter int unsigned ADDR_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mux_mode,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          irq,
  input  logic          loc_dout_we,
  input  logic [DW-1:0] loc_dout_wdata,
  input  logic          loc_din_rd,
  output logic [DW-1:0] loc_din,
  output logic [DW-1:0] loc_cmd,
  input  logic          loc_irq_set
);
  localparam int unsigned NPIN = 4;
  localparam int unsigned IX_CS = 0, IX_RD = 1, IX_WR = 2, IX_ALE = 3;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0111;

  logic [NPIN-1:0] pin_s;
  logic [1:0]      strb_rise;
  logic [DW-1:0]   dout, status;

  pslv_sync #(.N(NPIN), .RST(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({ale, wr_n, rd_n, cs_n}),
    .dout(pin_s)
  );

  pslv_edge #(.N(2), .RST(2'b11)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({pin_s[IX_WR], pin_s[IX_RD]}),
    .rise(strb_rise)
  );

  // Named internal events
  wire cs_act = ~pin_s[IX_CS];
  wire ale_s  = pin_s[IX_ALE];
  wire rd_end = cs_act & strb_rise[0];
  wire wr_end = cs_act & strb_rise[1];
  logic sel;

  pslv_addr u_addr (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode),
    .ale_s(ale_s), .addr_bit(bus_in[ADDR_BIT]), .sel(sel)
  );

  wire wr_din_evt  = wr_end & ~sel;
  wire wr_cmd_evt  = wr_end &  sel;
  wire rd_dout_evt = rd_end & ~sel;
  wire rd_stat_evt = rd_end &  sel;

  pslv_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_din_evt(wr_din_evt), .wr_cmd_evt(wr_cmd_evt),
    .rd_dout_evt(rd_dout_evt), .rd_stat_evt(rd_stat_evt),
    .bus_in(bus_in),
    .loc_dout_we(loc_dout_we), .loc_dout_wdata(loc_dout_wdata),
    .loc_din_rd(loc_din_rd), .loc_irq_set(loc_irq_set),
    .dout(dout), .din(loc_din), .cmd(loc_cmd), .status(status), .irq(irq)
  );

  assign bus_oe  = cs_act & ~pin_s[IX_RD];
  assign bus_out = bus_oe ? (sel ? status : dout) : '0;
endmodule

// File: rtl/pslv_port_chk.sv
module pslv_port_chk import pslv_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mux_mode,
  input logic          ale_s,
  input logic          sel,
  input logic          wr_din_evt,
  input logic          wr_cmd_evt,
  input logic          rd_stat_evt,
  input logic [DW-1:0] loc_din,
  input logic [DW-1:0] loc_cmd,
  input logic [DW-1:0] status,
  input logic          loc_dout_we,
  input logic          loc_irq_set,
  input logic          irq
);
  // R5: data-in changes only on a master write to it
  p_din_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_din_evt |=> $stable(loc_din));
  // R5: command changes only on a master write to it
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd_evt |=> $stable(loc_cmd));
  // R8: a master write to data-in leaves the full flag set
  p_ibf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_din_evt |=> status[ST_IBF]);
  // R9: a local data-out write leaves the full flag set
  p_obf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_dout_we |=> status[ST_OBF]);
  // R10: set request raises the interrupt
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_irq_set |=> irq);
  // R10: interrupt only drops after a status read
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_stat_evt) |=> irq);
  // R6: in multiplexed mode the select holds while the latch is closed
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mode && !ale_s) |=> (!mux_mode || $stable(sel)));
endmodule

bind pslv_port pslv_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .ale_s(ale_s), .sel(sel),
  .wr_din_evt(wr_din_evt), .wr_cmd_evt(wr_cmd_evt), .rd_stat_evt(rd_stat_evt),
  .loc_din(loc_din), .loc_cmd(loc_cmd), .status(status),
  .loc_dout_we(loc_dout_we), .loc_irq_set(loc_irq_set), .irq(irq)
);

// File: tb/test_pslv_port.sv
`timescale 1ns/1ps
module test_pslv_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0, cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic bus_oe, irq;
  logic loc_dout_we = 1'b0, loc_din_rd = 1'b0, loc_irq_set = 1'b0;
  logic [7:0] loc_dout_wdata = '0;
  logic [7:0] loc_din, loc_cmd;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pslv_port i_pslv_port (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .cs_n(cs_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .irq(irq), .loc_dout_we(loc_dout_we), .loc_dout_wdata(loc_dout_wdata),
    .loc_din_rd(loc_din_rd), .loc_din(loc_din), .loc_cmd(loc_cmd),
    .loc_irq_set(loc_irq_set)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Behavioural reference: pin history queues, index 1 = level seen by the core
  bit qc[$], qr[$], qw[$], qa[$];
  logic [7:0] m_dout, m_din, m_cmd;
  bit m_ibf, m_obf, m_irq, m_lat;

  function automatic logic [7:0] m_status();
    return {5'b0, m_irq, m_obf, m_ibf};
  endfunction

  always @(posedge clk) begin
    bit act, rrise, wrise, s;
    if (!rst_n) begin
      qc = '{1, 1, 1}; qr = '{1, 1, 1}; qw = '{1, 1, 1}; qa = '{0, 0, 0};
      m_dout = 0; m_din = 0; m_cmd = 0;
      m_ibf = 0; m_obf = 0; m_irq = 0; m_lat = 0;
    end else begin
      act   = !qc[1];
      rrise = act && qr[1] && !qr[2];
      wrise = act && qw[1] && !qw[2];
      s     = mux_mode ? m_lat : qa[1];
      if (rrise && !s) m_obf = 0;
      if (rrise && s)  m_irq = 0;
      if (loc_din_rd)  m_ibf = 0;
      if (wrise && !s) begin m_din = bus_in; m_ibf = 1; end
      if (wrise && s)  m_cmd = bus_in;
      if (loc_dout_we) begin m_dout = loc_dout_wdata; m_obf = 1; end
      if (loc_irq_set) m_irq = 1;
      if (qa[1]) m_lat = bus_in[1];
      qc.push_front(cs_n); void'(qc.pop_back());
      qr.push_front(rd_n); void'(qr.pop_back());
      qw.push_front(wr_n); void'(qw.pop_back());
      qa.push_front(ale);  void'(qa.pop_back());
    end
  end

  // Per-cycle comparison, 1 ns after the falling edge
  always @(negedge clk) begin
    bit e_oe, s;
    logic [7:0] e_out;
    #1;
    if (rst_n && !done) begin
      e_oe  = !qc[1] && !qr[1];
      s     = mux_mode ? m_lat : qa[1];
      e_out = e_oe ? (s ? m_status() : m_dout) : 8'h00;
      check(bus_oe === e_oe, "R3 bus_oe", {7'b0, bus_oe}, {7'b0, e_oe});
      check(bus_out === e_out, "R4 bus_out", bus_out, e_out);
      check(irq === m_irq, "R10 irq", {7'b0, irq}, {7'b0, m_irq});
      check(loc_din === m_din, "R5 loc_din", loc_din, m_din);
      check(loc_cmd === m_cmd, "R5 loc_cmd", loc_cmd, m_cmd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addr_phase(input bit s);
    if (mux_mode) begin
      cs_n = 0; bus_in = s ? 8'h02 : 8'h00; ale = 1; cyc(3);
      ale = 0; cyc(4);
    end else begin
      ale = s; cs_n = 0; cyc(2);
    end
  endtask

  task automatic m_write(input bit s, input logic [7:0] d);
    addr_phase(s);
    bus_in = d; cyc(1);
    wr_n = 0; cyc(4);
    wr_n = 1; cyc(5);
    cs_n = 1; ale = 0; cyc(4);
  endtask

  task automatic m_read(input bit s, output logic [7:0] d);
    addr_phase(s);
    bus_in = 8'h00; cyc(1);
    rd_n = 0; cyc(4); #1;
    d = bus_out;
    rd_n = 1; cyc(4);
    cs_n = 1; ale = 0; cyc(4);
  endtask

  task automatic loc_wr(input logic [7:0] d);
    loc_dout_we = 1; loc_dout_wdata = d; cyc(1); loc_dout_we = 0; cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    cyc(4); rst_n = 1; cyc(2); #1;
    check(bus_oe == 0, "R1 oe", {7'b0, bus_oe}, 8'h00);
    check(bus_out == 0, "R1 out", bus_out, 8'h00);
    check(irq == 0, "R1 irq", {7'b0, irq}, 8'h00);
    check(loc_din == 0 && loc_cmd == 0, "R1 regs", loc_din | loc_cmd, 8'h00);
    m_read(1, rd); check(rd == 8'h00, "R1 status", rd, 8'h00);

    // demultiplexed mode
    loc_wr(8'hA5);
    m_read(1, rd); check(rd == 8'h02, "R9 obf set", rd, 8'h02);
    m_read(0, rd); check(rd == 8'hA5, "R4 dout", rd, 8'hA5);
    m_read(1, rd); check(rd == 8'h00, "R9 obf clear", rd, 8'h00);

    m_write(0, 8'h3C); #1;
    check(loc_din == 8'h3C, "R5 din", loc_din, 8'h3C);
    m_read(1, rd); check(rd == 8'h01, "R8 ibf set", rd, 8'h01);
    loc_din_rd = 1; cyc(1); loc_din_rd = 0; cyc(1);
    m_read(1, rd); check(rd == 8'h00, "R8 ibf clear", rd, 8'h00);

    m_write(1, 8'h7E); #1;
    check(loc_cmd == 8'h7E, "R5 cmd", loc_cmd, 8'h7E);
    check(loc_din == 8'h3C, "R5 din kept", loc_din, 8'h3C);

    // strobes with chip select high
    cs_n = 1; ale = 0; bus_in = 8'h55; cyc(1);
    wr_n = 0; cyc(4); wr_n = 1; cyc(4);
    rd_n = 0; cyc(4); #1;
    check(bus_oe == 0, "R2 no drive", {7'b0, bus_oe}, 8'h00);
    rd_n = 1; cyc(5); #1;
    check(loc_din == 8'h3C, "R2 din", loc_din, 8'h3C);
    check(loc_cmd == 8'h7E, "R2 cmd", loc_cmd, 8'h7E);
    m_read(1, rd); check(rd == 8'h00, "R2 status", rd, 8'h00);

    // interrupt
    loc_irq_set = 1; cyc(1); loc_irq_set = 0; cyc(2); #1;
    check(irq == 1, "R10 raise", {7'b0, irq}, 8'h01);
    m_read(1, rd); check(rd == 8'h04, "R10 status", rd, 8'h04); #1;
    check(irq == 0, "R10 clear", {7'b0, irq}, 8'h00);
    loc_irq_set = 1; cyc(1);
    m_read(1, rd); check(rd == 8'h04, "R10 status held", rd, 8'h04);
    loc_irq_set = 0; cyc(1); #1;
    check(irq == 1, "R10 set wins", {7'b0, irq}, 8'h01);
    m_read(1, rd); #1; check(irq == 0, "R10 clear2", {7'b0, irq}, 8'h00);

    // data-out set wins over master read
    loc_dout_we = 1; loc_dout_wdata = 8'h5A; cyc(1);
    m_read(0, rd); check(rd == 8'h5A, "R9 dout held", rd, 8'h5A);
    loc_dout_we = 0; cyc(1);
    m_read(1, rd); check(rd == 8'h02, "R9 set wins", rd, 8'h02);
    m_read(0, rd); m_read(1, rd); check(rd == 8'h00, "R9 clear2", rd, 8'h00);

    // demultiplexed: bus bit 1 does not select
    m_write(0, 8'h02); #1;
    check(loc_din == 8'h02 && loc_cmd == 8'h7E, "R7 select by ale", loc_din, 8'h02);

    // multiplexed mode
    cyc(1); mux_mode = 1; cyc(2);
    m_write(1, 8'h11); #1;
    check(loc_cmd == 8'h11, "R6 cmd", loc_cmd, 8'h11);
    m_write(0, 8'hFF); #1;
    check(loc_din == 8'hFF, "R6 din", loc_din, 8'hFF);
    check(loc_cmd == 8'h11, "R6 latched sel", loc_cmd, 8'h11);
    m_read(0, rd); check(rd == 8'h5A, "R6 read dout", rd, 8'h5A);
    m_read(1, rd); check(rd == 8'h01, "R6 read status", rd, 8'h01);

    cyc(4);
    finish_run();
  end
endmodule